// File: doc/BRIEF.md
# Byte-Loaded Command Length Counter

This block holds the length of the command now running in a test-bus controller: the number of clock periods a run-test command idles, or the number of bits a scan command shifts. The host reaches the counter through an 8-bit port. Four writes to the counter address build the full value, and four reads return it. The lowest byte moves first in both directions. Separate pointers track the write and read sequences, and each wraps after the fourth access.

The command engine sends one strobe for each clock period or shifted bit, and each strobe lowers the count by one. A zero output tells the engine that the working state is over. A loaded flag shows whether a complete value is present, and it also appears as bit 5 of an 8-bit status byte. When the engine asks to start a command that needs the counter, the block answers with an accept pulse. If no complete value is loaded, it answers with an error pulse instead, and the command does not start. The asynchronous reset and a synchronous software clear both return the block to zero and unloaded.

Top module: `byte_cmd_counter`

## Requirements
- R1: While rst_n is low, and in the cycle after sw_clear is sampled high, the count, loaded flag, status byte, read data and start pulses are all zero. The next write goes to byte 0 and the next read to byte 0.
- R2: Four host writes place their bytes into count bits 7:0, 15:8, 23:16 and 31:24, in that order. Each write appears on count_out in the cycle after its strobe.
- R3: loaded rises only in the cycle after the fourth write of a sequence. The first write of a sequence clears it.
- R4: status_byte bit 5 equals loaded, and all other status bits read as zero.
- R5: A dec_strobe while loaded is set and the count is nonzero lowers the count by exactly one. If a host write falls in the same cycle, the write is applied and the strobe is ignored.
- R6: A dec_strobe while loaded is clear leaves the count unchanged.
- R7: count_zero is high exactly when the count is zero. A decrement from 1 to 0 clears loaded. A strobe at a loaded zero count clears loaded and does not wrap.
- R8: The first read of a sequence snapshots the whole count. The four reads return bytes 0 to 3 of that snapshot, unaffected by any later decrement or write. Each byte appears on host_rdata in the cycle after its strobe and holds until the next read.
- R9: start_req with loaded set gives a one-cycle start_ok in the next cycle. With loaded clear it gives a one-cycle start_err instead. The two never assert together.
- R10: The write and read pointers advance only on their own strobe. Each wraps to byte 0 after byte 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clear | input | 1 | Synchronous software clear |
| host_wr | input | 1 | Host write strobe to the counter address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe to the counter address |
| host_rdata | output | 8 | Registered read byte |
| dec_strobe | input | 1 | Decrement request from the command engine |
| start_req | input | 1 | Engine asks to start a counter-based command |
| start_ok | output | 1 | Start accepted pulse |
| start_err | output | 1 | Start refused (counter unloaded) pulse |
| count_out | output | 32 | Live count value |
| count_zero | output | 1 | Count equals zero |
| loaded | output | 1 | Full value present |
| status_byte | output | 8 | Status byte, loaded at bit 5 |

## Verification
The assertions expect the strobes to be clean one-cycle-per-access signals. They also expect any simultaneous write and decrement to be settled by the write-first rule. No further ordering between the host and the engine is assumed. The random stimulus draws each strobe independently, including host writes that collide with decrements and reads that interleave with writes. It keeps software clears rare, so that complete load and read sequences occur often. Upper write bytes are mostly zero, so counts reach zero inside the run and the zero, expiry and no-wrap paths are exercised.

// File: rtl/cmdcnt_pkg.sv
package cmdcnt_pkg;
  parameter int unsigned HOST_W_DEF      = 8;
  parameter int unsigned CNT_W_DEF       = 32;
  parameter int unsigned LOADED_BIT_DEF  = 5;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_STEP  = 2'd1,
    DEC_LAST  = 2'd2,
    DEC_EMPTY = 2'd3
  } dec_kind_e;
endpackage

// File: rtl/cmdcnt_ptr.sv
module cmdcnt_ptr #(
  parameter int unsigned N = 4,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          at_last;
  logic          ptr_en;

  assign at_last = (ptr_q == PW'(N - 1));
  assign ptr_en  = clr | adv;

  always_comb begin
    if (clr)          ptr_d = '0;
    else if (at_last) ptr_d = '0;
    else              ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == PW'(N - 1)) |=> (ptr_q == '0));
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q != PW'(N - 1)) |=> (ptr_q == $past(ptr_q) + 1'b1));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr_q));
endmodule

// File: rtl/cmdcnt_core.sv
module cmdcnt_core
  import cmdcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned HOST_W = HOST_W_DEF,
  localparam int unsigned NL = CNT_W / HOST_W,
  localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_lane,
  input  logic [HOST_W-1:0] wr_byte,
  input  logic              dec,
  output logic [CNT_W-1:0]  value,
  output logic              loaded,
  output logic              zero
);
  logic [CNT_W-1:0] value_q, value_d, merged;
  logic             loaded_q, loaded_d;
  logic             wr_first, wr_last;
  logic             val_en, ld_en;
  dec_kind_e        dkind;

  assign wr_first = (wr_lane == '0);
  assign wr_last  = (wr_lane == PW'(NL - 1));
  assign zero     = (value_q == '0);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign merged[g*HOST_W +: HOST_W] =
      (wr_lane == PW'(g)) ? wr_byte : value_q[g*HOST_W +: HOST_W];
  end

  always_comb begin
    dkind = DEC_NONE;
    if (!wr_en && dec && loaded_q) begin
      if (value_q == '0)                dkind = DEC_EMPTY;
      else if (value_q == CNT_W'(1))    dkind = DEC_LAST;
      else                              dkind = DEC_STEP;
    end
  end

  always_comb begin
    value_d  = value_q;
    loaded_d = loaded_q;
    if (clr) begin
      value_d  = '0;
      loaded_d = 1'b0;
    end else if (wr_en) begin
      value_d = merged;
      if (wr_last)       loaded_d = 1'b1;
      else if (wr_first) loaded_d = 1'b0;
    end else begin
      case (dkind)
        DEC_STEP:  value_d = value_q - 1'b1;
        DEC_LAST:  begin value_d = '0; loaded_d = 1'b0; end
        DEC_EMPTY: loaded_d = 1'b0;
        default:   ;
      endcase
    end
  end

  assign val_en = clr | wr_en | (dkind == DEC_STEP) | (dkind == DEC_LAST);
  assign ld_en  = clr | wr_en | (dkind == DEC_LAST) | (dkind == DEC_EMPTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (val_en) value_q <= value_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     loaded_q <= 1'b0;
    else if (ld_en) loaded_q <= loaded_d;
  end

  assign value  = value_q;
  assign loaded = loaded_q;

  a_r6_unloaded_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_q && !wr_en && !clr) |=> $stable(value_q));
  a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && dec && !wr_en && !clr && value_q != '0) |=> (value_q == $past(value_q) - 1'b1));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q == '0 && !wr_en) |=> (value_q == '0));
  a_r3_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_q) |-> $past(wr_en && wr_lane == PW'(NL - 1)));
  a_r7_expire_unloads: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && dec && !wr_en && value_q == CNT_W'(1)) |=> !loaded_q);
endmodule

// File: rtl/cmdcnt_rdhold.sv
module cmdcnt_rdhold #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HOST_W = 8,
  localparam int unsigned NL = CNT_W / HOST_W,
  localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [PW-1:0]     rd_lane,
  input  logic [CNT_W-1:0]  live,
  output logic [HOST_W-1:0] rdata
);
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic [HOST_W-1:0] rdata_q, rdata_d, lane_sel;
  logic              rd_first;
  logic              hold_en, rdata_en;

  assign rd_first = (rd_lane == '0);

  always_comb begin
    lane_sel = '0;
    for (int i = 0; i < NL; i++) begin
      if (rd_lane == PW'(i)) lane_sel = hold_q[i*HOST_W +: HOST_W];
    end
  end

  always_comb begin
    hold_d  = hold_q;
    rdata_d = rdata_q;
    if (clr) begin
      hold_d  = '0;
      rdata_d = '0;
    end else if (rd_en) begin
      if (rd_first) begin
        hold_d  = live;
        rdata_d = live[HOST_W-1:0];
      end else begin
        rdata_d = lane_sel;
      end
    end
  end

  assign hold_en  = clr | (rd_en & rd_first);
  assign rdata_en = clr | rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !clr) |=> $stable(rdata_q));
  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_first && !clr) |=> (hold_q == $past(live)));
  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_en && rd_first) && !clr) |=> $stable(hold_q));
endmodule

// File: rtl/byte_cmd_counter.sv
module byte_cmd_counter
  import cmdcnt_pkg::*;
#(
  parameter int unsigned CNT_W      = CNT_W_DEF,
  parameter int unsigned HOST_W     = HOST_W_DEF,
  parameter int unsigned LOADED_BIT = LOADED_BIT_DEF,
  localparam int unsigned NL = CNT_W / HOST_W,
  localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_clear,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              dec_strobe,
  input  logic              start_req,
  output logic              start_ok,
  output logic              start_err,
  output logic [CNT_W-1:0]  count_out,
  output logic              count_zero,
  output logic              loaded,
  output logic [HOST_W-1:0] status_byte
);
  logic [PW-1:0] wr_lane, rd_lane;
  logic          loaded_w;
  logic          ok_q, ok_d, err_q, err_d;

  cmdcnt_ptr #(.N(NL)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .adv(host_wr), .ptr(wr_lane)
  );

  cmdcnt_ptr #(.N(NL)) u_rptr (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .adv(host_rd), .ptr(rd_lane)
  );

  cmdcnt_core #(.CNT_W(CNT_W), .HOST_W(HOST_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear),
    .wr_en(host_wr), .wr_lane(wr_lane), .wr_byte(host_wdata),
    .dec(dec_strobe),
    .value(count_out), .loaded(loaded_w), .zero(count_zero)
  );

  cmdcnt_rdhold #(.CNT_W(CNT_W), .HOST_W(HOST_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear),
    .rd_en(host_rd), .rd_lane(rd_lane), .live(count_out),
    .rdata(host_rdata)
  );

  for (genvar b = 0; b < HOST_W; b++) begin : g_stat
    if (b == LOADED_BIT) begin : g_ld
      assign status_byte[b] = loaded_w;
    end else begin : g_zero
      assign status_byte[b] = 1'b0;
    end
  end

  always_comb begin
    ok_d  = 1'b0;
    err_d = 1'b0;
    if (!sw_clear && start_req) begin
      ok_d  = loaded_w;
      err_d = ~loaded_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      err_q <= err_d;
    end
  end

  assign start_ok  = ok_q;
  assign start_err = err_q;
  assign loaded    = loaded_w;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && start_err));
  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !loaded_w && !sw_clear) |=> (start_err && !start_ok));
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && loaded_w && !sw_clear) |=> start_ok);
  a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (count_out == '0 && !loaded_w && host_rdata == '0 && !start_ok && !start_err));
endmodule

// File: tb/byte_cmd_counter_tb_top.sv
module byte_cmd_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_clear, host_wr, host_rd, dec_strobe, start_req;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata, status_byte;
  logic        start_ok, start_err, count_zero, loaded;
  logic [31:0] count_out;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  logic [31:0] m_val, m_hold;
  logic        m_ld, m_ok, m_err;
  logic [7:0]  m_rdata;
  logic [1:0]  m_wp, m_rp;

  always #5 clk = ~clk;

  byte_cmd_counter dut_i (
    .clk(clk), .rst_n(rst_n), .sw_clear(sw_clear),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .dec_strobe(dec_strobe), .start_req(start_req),
    .start_ok(start_ok), .start_err(start_err),
    .count_out(count_out), .count_zero(count_zero),
    .loaded(loaded), .status_byte(status_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] put_lane(input logic [31:0] v, input logic [1:0] l,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = v;
    r[l*8 +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] get_lane(input logic [31:0] v, input logic [1:0] l);
    return v[l*8 +: 8];
  endfunction

  task automatic model_reset();
    m_val = '0; m_hold = '0; m_ld = 1'b0; m_ok = 1'b0; m_err = 1'b0;
    m_rdata = '0; m_wp = '0; m_rp = '0;
  endtask

  task automatic check_all(input string tag);
    chk({"R2/R5 count ", tag}, count_out, m_val);
    chk({"R3 loaded ", tag}, {31'd0, loaded}, {31'd0, m_ld});
    chk({"R7 zero ", tag}, {31'd0, count_zero}, {31'd0, (m_val == 0)});
    chk({"R4 status ", tag}, {24'd0, status_byte}, {24'd0, 2'b00, m_ld, 5'b00000});
    chk({"R8 rdata ", tag}, {24'd0, host_rdata}, {24'd0, m_rdata});
    chk({"R9 start ", tag}, {30'd0, start_ok, start_err}, {30'd0, m_ok, m_err});
  endtask

  // drives at negedge, models the edge, checks at the following negedge
  task automatic step(input logic clr, input logic wr, input logic [7:0] wd,
                      input logic rd, input logic dec, input logic st, input string tag);
    logic [31:0] v0;
    logic        l0;
    sw_clear = clr; host_wr = wr; host_wdata = wd; host_rd = rd;
    dec_strobe = dec; start_req = st;
    @(posedge clk);
    v0 = m_val; l0 = m_ld;
    if (clr) model_reset();
    else begin
      if (wr) begin
        m_val = put_lane(m_val, m_wp, wd);
        if (m_wp == 2'd3) m_ld = 1'b1;
        else if (m_wp == 2'd0) m_ld = 1'b0;
        m_wp = m_wp + 1'b1;
      end else if (dec && l0) begin
        if (v0 != 0) m_val = v0 - 1;
        if (v0 <= 1) m_ld = 1'b0;
      end
      if (rd) begin
        if (m_rp == 2'd0) begin m_hold = v0; m_rdata = v0[7:0]; end
        else m_rdata = get_lane(m_hold, m_rp);
        m_rp = m_rp + 1'b1;
      end
      m_ok  = st & l0;
      m_err = st & ~l0;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic load_value(input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) step(0, 1, v[i*8 +: 8], 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C47));
    rst_n = 1'b0; sw_clear = 0; host_wr = 0; host_wdata = 0; host_rd = 0;
    dec_strobe = 0; start_req = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R9 refused while unloaded, R6 dec ignored
    step(0, 0, 0, 0, 1, 1, "R6/R9 unloaded");
    step(0, 0, 0, 0, 0, 0, "R9 pulse end");

    // R2/R3 load, R8 read across decrement
    step(0, 1, 8'h78, 0, 0, 0, "R3 partial");
    step(0, 1, 8'h56, 0, 0, 1, "R9 partial");
    step(0, 1, 8'h34, 0, 0, 0, "R3 partial");
    step(0, 1, 8'h12, 0, 0, 0, "R3 fourth");
    step(0, 0, 0, 1, 1, 1, "R8 first read");
    step(0, 0, 0, 1, 1, 0, "R8 read1");
    step(0, 1, 8'hAA, 1, 1, 0, "R5 write priority");
    step(0, 0, 0, 1, 0, 0, "R8 read3");
    step(0, 0, 0, 0, 0, 0, "R8 hold");

    // R7 expiry and no wrap
    load_value(32'h0000_0002, "R2 small");
    step(0, 0, 0, 0, 1, 0, "R5 step");
    step(0, 0, 0, 0, 1, 0, "R7 last");
    step(0, 0, 0, 0, 1, 0, "R7 no wrap");
    load_value(32'h0, "R7 zero load");
    step(0, 0, 0, 0, 1, 1, "R7 empty");

    // R1 software clear mid-sequence
    step(0, 1, 8'h11, 1, 0, 0, "R10 partial");
    step(1, 0, 0, 0, 0, 0, "R1 sw clear");
    load_value(32'hCAFE_0003, "R10 after clear");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] wd;
      logic       c;
      c  = ($urandom_range(0, 199) == 0);
      wd = (m_wp != 0 && $urandom_range(0, 3) != 0) ? 8'h00 : 8'($urandom);
      step(c, ($urandom_range(0, 3) == 0), wd, ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 1) == 0), ($urandom_range(0, 7) == 0), "random");
    end

    // R1 asynchronous reset mid-run
    load_value(32'h0101_0101, "R1 preload");
    #2 rst_n = 1'b0;
    model_reset();
    #1 check_all("R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 8'h44, 1, 0, 0, "R1 pointers");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule